// File: doc/BRIEF.md
# SMRAM Access Control Unit

This unit decides where an access aimed at the legacy video segment goes. A 64 KB system-management RAM window can sit in that segment. The unit routes each access either to DRAM, where the SMRAM lives, or to PCI, where the video memory lives. One 8-bit control byte governs the routing, and a configuration write port loads it. The decision also depends on three inputs: an SMM-active flag, the access address, and a flag that marks a code fetch as opposed to a data access.

Three of the control bits work together:

- The segment field places the window at A0000h or B0000h.
- The open bit exposes the window to ordinary code. It does so only when the window is placed at A0000h.
- The close bit lets a handler running in SMM send its data accesses to the video memory on PCI, while its instruction fetches still come from SMRAM.

A lock bit freezes the whole byte until the next reset. Software cannot clear it.

The routing decision is combinational and depends on the registered control byte. `route_dram_o` is meaningful only while `win_hit_o` is high. Outside the window the unit drives it low, and other decoders make the decision.

Top module: `smram_access_ctrl`

## Requirements
- R1: After reset the control byte reads 00h, lock included, and no address hits the window.
- R2: A write while unlocked stores bits 5-0 (bit 5 open, bit 4 close, bit 3 lock, bits 2-0 segment). Bits 7-6 always read 0.
- R3: Once lock (bit 3) is set, writes change no bit of the control byte, and lock stays set until reset.
- R4: Segment code 010 places the window at A0000h-AFFFFh and code 011 places it at B0000h-BFFFFh, with all higher address bits zero. Any other code places no window. `win_hit_o` is high only for addresses inside the placed window.
- R5: Outside SMM, a window access goes to DRAM only when open is set and the segment code is 010. Otherwise it goes to PCI.
- R6: In SMM, a code fetch inside the window goes to DRAM whatever the open and close bits hold.
- R7: In SMM, a data access inside the window goes to DRAM when close is 0 and to PCI when close is 1.
- R8: An access outside the window drives `route_dram_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control byte write strobe |
| cfg_wdata_i | input | 8 | Control byte write data |
| cfg_rdata_o | output | 8 | Control byte read-back |
| smm_active_i | input | 1 | Processor is in system management mode |
| acc_addr_i | input | ADDR_W (32) | Access address |
| acc_fetch_i | input | 1 | 1 = code fetch, 0 = data access |
| win_hit_o | output | 1 | Access falls inside the placed window |
| route_dram_o | output | 1 | 1 = send to DRAM, 0 = forward to PCI |

## Verification
The assertions guard the following on every cycle:

- Reserved bits read as zero.
- Lock is sticky.
- A write while locked leaves the byte unchanged.
- An SMM code fetch inside the window goes to DRAM.
- A closed window outside SMM goes to PCI.
- A miss never routes to DRAM.

Some behaviour only the directed scenarios can show:

- Bytes written while unlocked are masked correctly.
- Each segment code places the window at the right address range.
- The open bit has no effect while the window sits at B0000h.
- The close bit splits data accesses from fetches.
- Reset clears a set lock.

// File: rtl/smram_pkg.sv
package smram_pkg;
  typedef struct packed {
    logic [1:0] rsvd;
    logic       open;
    logic       close;
    logic       lock;
    logic [2:0] seg;
  } smram_ctrl_t;

  localparam logic [7:0] CTRL_WR_MASK = 8'h3F;
  localparam logic [2:0] SEG_A_CODE   = 3'b010;
  localparam logic [1:0] SEG_VALID_HI = 2'b01;
endpackage

// File: rtl/smram_ctrl_reg.sv
module smram_ctrl_reg
  import smram_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  wdata_i,
  output smram_ctrl_t ctrl_o
);
  smram_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ctrl_q <= '0;
    else if (we_i && !ctrl_q.lock)  ctrl_q <= smram_ctrl_t'(wdata_i & CTRL_WR_MASK);
  end

  assign ctrl_o = ctrl_q;

  // R3
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.lock |=> ctrl_q.lock);
  // R3
  locked_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.lock && we_i) |=> $stable(ctrl_q));
endmodule

// File: rtl/smram_win_decode.sv
module smram_win_decode #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEG_SHIFT = 16,
  parameter int unsigned SEG_BASE  = 'hA
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        seg_i,
  output logic              hit_o
);
  import smram_pkg::*;
  localparam int unsigned TAG_W = ADDR_W - SEG_SHIFT;

  logic             seg_ok;
  logic [TAG_W-1:0] tag;

  // codes 010/011 map to consecutive 64 KB segments from SEG_BASE
  assign seg_ok = (seg_i[2:1] == SEG_VALID_HI);
  assign tag    = TAG_W'(SEG_BASE) + TAG_W'(seg_i[0]);
  assign hit_o  = seg_ok && (addr_i[ADDR_W-1:SEG_SHIFT] == tag);
endmodule

// File: rtl/smram_route.sv
module smram_route
  import smram_pkg::*;
(
  input  logic        hit_i,
  input  logic        smm_i,
  input  logic        fetch_i,
  input  smram_ctrl_t ctrl_i,
  output logic        dram_o
);
  logic open_eff;

  // window opens to normal code only in the A segment
  assign open_eff = ctrl_i.open && (ctrl_i.seg == SEG_A_CODE);

  always_comb begin
    if (!hit_i)      dram_o = 1'b0;
    else if (smm_i)  dram_o = fetch_i ? 1'b1 : !ctrl_i.close;
    else             dram_o = open_eff;
  end
endmodule

// File: rtl/smram_access_ctrl.sv
module smram_access_ctrl
  import smram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEG_SHIFT = 16,
  parameter int unsigned SEG_BASE  = 'hA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              smm_active_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_fetch_i,
  output logic              win_hit_o,
  output logic              route_dram_o
);
  smram_ctrl_t ctrl;

  smram_ctrl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .ctrl_o  (ctrl)
  );

  smram_win_decode #(
    .ADDR_W    (ADDR_W),
    .SEG_SHIFT (SEG_SHIFT),
    .SEG_BASE  (SEG_BASE)
  ) u_dec (
    .addr_i (acc_addr_i),
    .seg_i  (ctrl.seg),
    .hit_o  (win_hit_o)
  );

  smram_route u_route (
    .hit_i   (win_hit_o),
    .smm_i   (smm_active_i),
    .fetch_i (acc_fetch_i),
    .ctrl_i  (ctrl),
    .dram_o  (route_dram_o)
  );

  assign cfg_rdata_o = ctrl;

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[7:6] == 2'b00);
  // R6
  smm_fetch_dram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smm_active_i && win_hit_o && acc_fetch_i) |-> route_dram_o);
  // R5
  closed_to_pci_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smm_active_i && !cfg_rdata_o[5]) |-> !route_dram_o);
  // R8
  miss_no_dram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_hit_o |-> !route_dram_o);
endmodule

// File: tb/tb_smram_access_ctrl.sv
`timescale 1ns/1ps
module tb_smram_access_ctrl;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              smm = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              fetch = 1'b0;
  logic              hit;
  logic              dram;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  smram_access_ctrl #(.ADDR_W(ADDR_W)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_we_i     (we),
    .cfg_wdata_i  (wdata),
    .cfg_rdata_o  (rdata),
    .smm_active_i (smm),
    .acc_addr_i   (addr),
    .acc_fetch_i  (fetch),
    .win_hit_o    (hit),
    .route_dram_o (dram)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic acc(input logic [ADDR_W-1:0] a, input logic s, input logic f);
    @(negedge clk); addr = a; smm = s; fetch = f;
    #1;
  endtask

  task automatic t_reset();
    wr(8'h3A);
    do_reset();
    chk("R1 rdata after reset", rdata, 8'h00);
    acc(32'h000A_0000, 1'b1, 1'b1);
    chk("R1 no hit after reset", hit, 1'b0);
  endtask

  task automatic t_write_mask();
    do_reset();
    wr(8'hF7);
    chk("R2 masked write", rdata, 8'h37);
    wr(8'hC2);
    chk("R2 rsvd read zero", rdata, 8'h02);
  endtask

  task automatic t_lock();
    do_reset();
    wr(8'h2A);
    chk("R3 lock stored", rdata, 8'h2A);
    wr(8'h00);
    chk("R3 write ignored", rdata, 8'h2A);
    wr(8'h13);
    chk("R3 write ignored 2", rdata, 8'h2A);
    acc(32'h000A_8000, 1'b0, 1'b0);
    chk("R3 config frozen route", dram, 1'b1);
    do_reset();
    chk("R1 reset clears lock", rdata, 8'h00);
    wr(8'h03);
    chk("R3 writable after reset", rdata, 8'h03);
  endtask

  task automatic t_decode();
    do_reset();
    wr(8'h02);
    acc(32'h000A_1234, 1'b1, 1'b0);
    chk("R4 A seg hit", hit, 1'b1);
    acc(32'h000A_FFFF, 1'b1, 1'b0);
    chk("R4 A seg top hit", hit, 1'b1);
    acc(32'h000B_0000, 1'b1, 1'b0);
    chk("R4 B addr miss on A", hit, 1'b0);
    acc(32'h100A_0000, 1'b1, 1'b0);
    chk("R4 high bits miss", hit, 1'b0);
    chk("R8 miss no dram", dram, 1'b0);
    wr(8'h03);
    acc(32'h000B_FFFF, 1'b1, 1'b0);
    chk("R4 B seg hit", hit, 1'b1);
    acc(32'h0009_FFFF, 1'b1, 1'b0);
    chk("R4 below A miss", hit, 1'b0);
    acc(32'h000A_0000, 1'b1, 1'b0);
    chk("R4 A addr miss on B", hit, 1'b0);
    for (int c = 0; c < 8; c++) begin
      if (c == 2 || c == 3) continue;
      wr(8'(c));
      acc(32'h000A_0000, 1'b1, 1'b1);
      chk("R4 bad code A miss", hit, 1'b0);
      acc(32'h000B_0000, 1'b1, 1'b1);
      chk("R4 bad code B miss", hit, 1'b0);
    end
  endtask

  task automatic t_non_smm();
    do_reset();
    wr(8'h02);
    acc(32'h000A_4000, 1'b0, 1'b0);
    chk("R5 closed window pci", dram, 1'b0);
    acc(32'h000A_4000, 1'b0, 1'b1);
    chk("R5 closed window fetch pci", dram, 1'b0);
    wr(8'h22);
    acc(32'h000A_4000, 1'b0, 1'b0);
    chk("R5 open A dram", dram, 1'b1);
    acc(32'h000C_0000, 1'b0, 1'b0);
    chk("R8 open but miss", dram, 1'b0);
    wr(8'h23);
    acc(32'h000B_4000, 1'b0, 1'b0);
    chk("R5 open on B hit", hit, 1'b1);
    chk("R5 open on B pci", dram, 1'b0);
  endtask

  task automatic t_smm();
    do_reset();
    wr(8'h12);
    acc(32'h000A_0100, 1'b1, 1'b1);
    chk("R6 close fetch dram", dram, 1'b1);
    acc(32'h000A_0100, 1'b1, 1'b0);
    chk("R7 close data pci", dram, 1'b0);
    wr(8'h02);
    acc(32'h000A_0100, 1'b1, 1'b0);
    chk("R7 open data dram", dram, 1'b1);
    acc(32'h000A_0100, 1'b1, 1'b1);
    chk("R6 fetch dram", dram, 1'b1);
    wr(8'h13);
    acc(32'h000B_0100, 1'b1, 1'b1);
    chk("R6 B fetch dram", dram, 1'b1);
    acc(32'h000B_0100, 1'b1, 1'b0);
    chk("R7 B close data pci", dram, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 rdata in reset", rdata, 8'h00);
    t_reset();
    t_write_mask();
    t_lock();
    t_decode();
    t_non_smm();
    t_smm();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule